// File: doc/BRIEF.md
# Dual-Width Packet-Filter ALU

This block is the combinational execution unit of a packet-filter virtual machine. It takes the current value of the destination register, a second operand, an operation code, a width-mode flag and a size field. It returns the value to be written back into the destination register. The destination works as an accumulator: it is both the first operand and the target of the result.

The second operand is either a register value or a 32-bit signed immediate that is sign-extended to 64 bits. The same datapath serves full 64-bit operation and a 32-bit subregister mode. In the 32-bit mode only the low halves of the operands take part, and the upper half of the result is cleared.

Besides ordinary arithmetic, logic and shift operations, the unit performs sign-extending moves and byte-order conversions of selectable width. The host byte order is little-endian, so converting to little-endian only truncates to the selected width. Converting to big-endian reverses the bytes within that width, which makes it the byte-swap operation as well. Decoding, the register file and any multi-cycle division sequencing belong to the surrounding pipeline.

Top module: `pf_alu`

## Requirements
- R1: When `use_imm` is 0 the second operand is `src`. When it is 1 the second operand is `imm` sign-extended to 64 bits, so 32'hFFFFFFFF acts as minus one.
- R2: With `wide`=0, opcodes 0 to 13 compute on the low 32 bits of each operand and return bits 63:32 of `result` as zero.
- R3: Opcodes 0 add, 1 subtract, 2 multiply, 5 and, 6 or and 7 xor combine `dst` with the second operand. The result wraps modulo 2^64, or 2^32 when `wide`=0.
- R4: Opcode 3 is unsigned division and opcode 4 is unsigned remainder of `dst` by the second operand. A zero divisor makes division return 0.
- R5: Remainder by a zero divisor returns `dst` unchanged when `wide`=1, and its low 32 bits zero-extended when `wide`=0. With `wide`=0 only the low 32 bits of the divisor decide whether it is zero.
- R6: Opcodes 8 (left shift), 9 (logical right shift, zero fill) and 10 (arithmetic right shift, sign fill) shift `dst` by the second operand. The shift amount is masked to 6 bits when `wide`=1 and to 5 bits when `wide`=0.
- R7: Opcode 11 returns the two's-complement negative of `dst`. Opcode 12 returns the second operand.
- R8: Opcode 13 sign-extends the low bits of the second operand to the operating width. `size` 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits.
- R9: Opcode 14, little-endian conversion, returns the low 16, 32 or 64 bits of `dst` zero-extended, for `size` 0, 1, or 2/3. It does not depend on `wide`.
- R10: Opcode 15, big-endian conversion and byte swap, returns the low 16, 32 or 64 bits of `dst` with their byte order reversed, zero-extended, for `size` 0, 1, or 2/3. It does not depend on `wide`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation code |
| wide | input | 1 | 1 selects 64-bit mode, 0 selects 32-bit subregister mode |
| use_imm | input | 1 | Selects the immediate as the second operand |
| size | input | 2 | Width field for sign-extending moves and byte-order conversion |
| dst | input | 64 | Current destination register value |
| src | input | 64 | Source register value |
| imm | input | 32 | Signed immediate |
| result | output | 64 | Value to write back to the destination |

## Verification
The hardest cases to reach are those where the 32-bit mode has to ignore upper operand bits that would change the answer. Examples are a divisor that is non-zero overall but zero in its low half, and a shift amount above 31 that must wrap. The stimulus sets the upper halves of `dst` and `src` to deliberately misleading patterns. Each expected value is then derived from the low halves alone. Sign-fill and sign-extension are driven with operands whose selected sign bit is set, so a zero fill would show.

// File: rtl/pf_alu.sv
module pf_alu (
  input  logic [3:0]  op,
  input  logic        wide,
  input  logic        use_imm,
  input  logic [1:0]  size,
  input  logic [63:0] dst,
  input  logic [63:0] src,
  input  logic [31:0] imm,
  output logic [63:0] result
);
  localparam int XW = 64;
  localparam int HW = 32;
  localparam int IW = 32;

  localparam logic [3:0] OP_ADD = 4'd0,  OP_SUB = 4'd1,  OP_MUL = 4'd2,  OP_DIV = 4'd3;
  localparam logic [3:0] OP_MOD = 4'd4,  OP_AND = 4'd5,  OP_OR  = 4'd6,  OP_XOR = 4'd7;
  localparam logic [3:0] OP_SHL = 4'd8,  OP_SHR = 4'd9,  OP_SAR = 4'd10, OP_NEG = 4'd11;
  localparam logic [3:0] OP_MOV = 4'd12, OP_SXM = 4'd13, OP_TLE = 4'd14, OP_TBE = 4'd15;

  logic [XW-1:0] b64, r64, ord;
  logic [HW-1:0] a32, b32, r32;
  logic [5:0]    sh64;
  logic [4:0]    sh32;

  assign b64  = use_imm ? {{(XW-IW){imm[IW-1]}}, imm} : src;
  assign a32  = dst[HW-1:0];
  assign b32  = b64[HW-1:0];
  assign sh64 = b64[5:0];
  assign sh32 = b32[4:0];

  always_comb begin
    case (op)
      OP_ADD:  r64 = dst + b64;
      OP_SUB:  r64 = dst - b64;
      OP_MUL:  r64 = dst * b64;
      OP_DIV:  r64 = (b64 == '0) ? '0 : dst / b64;
      OP_MOD:  r64 = (b64 == '0) ? dst : dst % b64;
      OP_AND:  r64 = dst & b64;
      OP_OR:   r64 = dst | b64;
      OP_XOR:  r64 = dst ^ b64;
      OP_SHL:  r64 = dst << sh64;
      OP_SHR:  r64 = dst >> sh64;
      OP_SAR:  r64 = $unsigned($signed(dst) >>> sh64);
      OP_NEG:  r64 = '0 - dst;
      OP_MOV:  r64 = b64;
      OP_SXM:  case (size)
                 2'd0:    r64 = {{(XW-8){b64[7]}}, b64[7:0]};
                 2'd1:    r64 = {{(XW-16){b64[15]}}, b64[15:0]};
                 default: r64 = {{(XW-32){b64[31]}}, b64[31:0]};
               endcase
      default: r64 = '0;
    endcase
  end

  always_comb begin
    case (op)
      OP_ADD:  r32 = a32 + b32;
      OP_SUB:  r32 = a32 - b32;
      OP_MUL:  r32 = a32 * b32;
      OP_DIV:  r32 = (b32 == '0) ? '0 : a32 / b32;
      OP_MOD:  r32 = (b32 == '0) ? a32 : a32 % b32;
      OP_AND:  r32 = a32 & b32;
      OP_OR:   r32 = a32 | b32;
      OP_XOR:  r32 = a32 ^ b32;
      OP_SHL:  r32 = a32 << sh32;
      OP_SHR:  r32 = a32 >> sh32;
      OP_SAR:  r32 = $unsigned($signed(a32) >>> sh32);
      OP_NEG:  r32 = '0 - a32;
      OP_MOV:  r32 = b32;
      OP_SXM:  case (size)
                 2'd0:    r32 = {{(HW-8){b32[7]}}, b32[7:0]};
                 2'd1:    r32 = {{(HW-16){b32[15]}}, b32[15:0]};
                 default: r32 = b32;
               endcase
      default: r32 = '0;
    endcase
  end

  always_comb begin
    ord = '0;
    for (int i = 0; i < XW/8; i++) begin
      case (size)
        2'd0:    if (i < 2) ord[8*i +: 8] = (op == OP_TBE) ? dst[8*(1-i) +: 8] : dst[8*i +: 8];
        2'd1:    if (i < 4) ord[8*i +: 8] = (op == OP_TBE) ? dst[8*(3-i) +: 8] : dst[8*i +: 8];
        default: ord[8*i +: 8] = (op == OP_TBE) ? dst[8*(7-i) +: 8] : dst[8*i +: 8];
      endcase
    end
  end

  assign result = (op == OP_TLE || op == OP_TBE) ? ord
                : wide ? r64 : {{(XW-HW){1'b0}}, r32};
endmodule

// File: rtl/pf_alu_chk.sv
module pf_alu_chk (
  input logic [3:0]  op,
  input logic        wide,
  input logic        use_imm,
  input logic [1:0]  size,
  input logic [63:0] dst,
  input logic [63:0] src,
  input logic [31:0] imm,
  input logic [63:0] result
);
  logic [63:0] opnd;
  assign opnd = use_imm ? {{32{imm[31]}}, imm} : src;

  always_comb begin
    if (!wide && op <= 4'd13)
      p_upper_clear_r2: assert (result[63:32] == 32'd0);
    if (op == 4'd3 && (wide ? opnd == 64'd0 : opnd[31:0] == 32'd0))
      p_div_zero_r4: assert (result == 64'd0);
    if (op == 4'd4 && (wide ? opnd == 64'd0 : opnd[31:0] == 32'd0))
      p_mod_zero_keep_r5: assert (result == (wide ? dst : {32'd0, dst[31:0]}));
    if (op == 4'd11 && wide)
      p_neg_sum_r7: assert (result + dst == 64'd0);
    if (op == 4'd13 && wide && size == 2'd0)
      p_sext_fill_r8: assert (result[63:8] == (opnd[7] ? {56{1'b1}} : 56'd0));
    if (op == 4'd14 && size == 2'd0)
      p_le_trunc_r9: assert (result == {48'd0, dst[15:0]});
    if (op == 4'd15 && size == 2'd1)
      p_be_swap_r10: assert (result == {32'd0, dst[7:0], dst[15:8], dst[23:16], dst[31:24]});
  end
endmodule

bind pf_alu pf_alu_chk u_chk (.*);

// File: tb/pf_alu_tb_top.sv
module pf_alu_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [3:0]  op;
  logic        wide, use_imm;
  logic [1:0]  size;
  logic [63:0] dst, src, result;
  logic [31:0] imm;

  int total = 0;
  int bad = 0;

  pf_alu dut_i (.op(op), .wide(wide), .use_imm(use_imm), .size(size),
                .dst(dst), .src(src), .imm(imm), .result(result));

  task automatic apply(input logic [3:0] o, input logic w, input logic ui, input logic [1:0] s,
                       input logic [63:0] d, input logic [63:0] r, input logic [31:0] i);
    @(negedge clk);
    op = o; wide = w; use_imm = ui; size = s; dst = d; src = r; imm = i;
    #1;
  endtask

  task automatic check(input string req, input logic [63:0] exp);
    total++;
    if (result !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, result, exp);
    end
  endtask

  task automatic t_reset;
    apply(4'd0, 1'b1, 1'b0, 2'd0, 64'd0, 64'd0, 32'd0);
    check("R3 idle zero", 64'd0);
  endtask

  task automatic t_operand;
    apply(4'd0, 1'b1, 1'b1, 2'd0, 64'd10, 64'd99, 32'hFFFFFFFF);
    check("R1 imm minus one", 64'd9);
    apply(4'd0, 1'b1, 1'b0, 2'd0, 64'd10, 64'd5, 32'hFFFFFFFF);
    check("R1 register", 64'd15);
  endtask

  task automatic t_arith;
    apply(4'd1, 1'b1, 1'b0, 2'd0, 64'd0, 64'd1, 32'd0);
    check("R3 sub wrap", 64'hFFFF_FFFF_FFFF_FFFF);
    apply(4'd2, 1'b0, 1'b0, 2'd0, 64'h1_0000_0003, 64'h8000_0001, 32'd0);
    check("R3 mul32", 64'h0000_0000_8000_0003);
    apply(4'd7, 1'b1, 1'b1, 2'd0, 64'h00FF_0000_0000_00F0, 64'd0, 32'h0000_00FF);
    check("R3 xor imm", 64'h00FF_0000_0000_000F);
    apply(4'd0, 1'b0, 1'b0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 32'd0);
    check("R2 add32 upper clear", 64'd0);
  endtask

  task automatic t_divide;
    apply(4'd3, 1'b1, 1'b0, 2'd0, 64'd100, 64'd7, 32'd0);
    check("R4 div", 64'd14);
    apply(4'd4, 1'b1, 1'b0, 2'd0, 64'd100, 64'd7, 32'd0);
    check("R4 mod", 64'd2);
    apply(4'd3, 1'b1, 1'b0, 2'd0, 64'd100, 64'd0, 32'd0);
    check("R4 div by zero", 64'd0);
    apply(4'd3, 1'b0, 1'b0, 2'd0, 64'hAAAA_0000_0000_0064, 64'h5555_0000_0000_0007, 32'd0);
    check("R4 div32 low halves", 64'd14);
    apply(4'd4, 1'b1, 1'b0, 2'd0, 64'hDEAD_BEEF_1234_5678, 64'd0, 32'd0);
    check("R5 mod zero wide", 64'hDEAD_BEEF_1234_5678);
    apply(4'd4, 1'b0, 1'b0, 2'd0, 64'hDEAD_BEEF_1234_5678, 64'h1_0000_0000, 32'd0);
    check("R5 mod zero low32", 64'h0000_0000_1234_5678);
  endtask

  task automatic t_shift;
    apply(4'd8, 1'b1, 1'b0, 2'd0, 64'd3, 64'd65, 32'd0);
    check("R6 shl mask6", 64'd6);
    apply(4'd10, 1'b1, 1'b0, 2'd0, 64'h8000_0000_0000_0000, 64'd4, 32'd0);
    check("R6 sar64", 64'hF800_0000_0000_0000);
    apply(4'd9, 1'b1, 1'b0, 2'd0, 64'h8000_0000_0000_0000, 64'd4, 32'd0);
    check("R6 shr64", 64'h0800_0000_0000_0000);
    apply(4'd10, 1'b0, 1'b1, 2'd0, 64'hFFFF_0000_8000_0000, 64'd0, 32'd33);
    check("R6 sar32 mask5", 64'h0000_0000_C000_0000);
    apply(4'd8, 1'b0, 1'b0, 2'd0, 64'd1, 64'd31, 32'd0);
    check("R6 shl32", 64'h0000_0000_8000_0000);
  endtask

  task automatic t_negmov;
    apply(4'd11, 1'b1, 1'b0, 2'd0, 64'd1, 64'd0, 32'd0);
    check("R7 neg64", 64'hFFFF_FFFF_FFFF_FFFF);
    apply(4'd11, 1'b0, 1'b0, 2'd0, 64'd1, 64'd0, 32'd0);
    check("R7 neg32", 64'h0000_0000_FFFF_FFFF);
    apply(4'd12, 1'b1, 1'b1, 2'd0, 64'd7, 64'd0, 32'h8000_0000);
    check("R7 mov imm64", 64'hFFFF_FFFF_8000_0000);
    apply(4'd12, 1'b0, 1'b1, 2'd0, 64'd7, 64'd0, 32'h8000_0000);
    check("R7 mov imm32", 64'h0000_0000_8000_0000);
  endtask

  task automatic t_sext;
    apply(4'd13, 1'b1, 1'b0, 2'd0, 64'd0, 64'h0000_0000_0000_0080, 32'd0);
    check("R8 sext8", 64'hFFFF_FFFF_FFFF_FF80);
    apply(4'd13, 1'b1, 1'b0, 2'd1, 64'd0, 64'h0000_0000_1234_7FFF, 32'd0);
    check("R8 sext16 positive", 64'h0000_0000_0000_7FFF);
    apply(4'd13, 1'b1, 1'b0, 2'd2, 64'd0, 64'h1234_5678_8000_0000, 32'd0);
    check("R8 sext32", 64'hFFFF_FFFF_8000_0000);
    apply(4'd13, 1'b0, 1'b0, 2'd0, 64'd0, 64'h0000_0000_0000_00FF, 32'd0);
    check("R8 sext8 in 32-bit mode", 64'h0000_0000_FFFF_FFFF);
  endtask

  task automatic t_order;
    logic [63:0] v = 64'h1122_3344_5566_7788;
    apply(4'd14, 1'b1, 1'b0, 2'd0, v, 64'd0, 32'd0);
    check("R9 le16", 64'h7788);
    apply(4'd14, 1'b0, 1'b0, 2'd1, v, 64'd0, 32'd0);
    check("R9 le32", 64'h5566_7788);
    apply(4'd14, 1'b0, 1'b0, 2'd2, v, 64'd0, 32'd0);
    check("R9 le64 ignores mode", v);
    apply(4'd15, 1'b1, 1'b0, 2'd0, v, 64'd0, 32'd0);
    check("R10 be16", 64'h8877);
    apply(4'd15, 1'b1, 1'b0, 2'd1, v, 64'd0, 32'd0);
    check("R10 be32", 64'h8877_6655);
    apply(4'd15, 1'b0, 1'b0, 2'd3, v, 64'd0, 32'd0);
    check("R10 be64 ignores mode", 64'h8877_6655_4433_2211);
  endtask

  initial begin
    op = '0; wide = 1'b1; use_imm = 1'b0; size = '0; dst = '0; src = '0; imm = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_operand();
    t_arith();
    t_divide();
    t_shift();
    t_negmov();
    t_sext();
    t_order();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule